// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block holds a small bank of event counters for a processor core. Each counter is tied by software to one source. That source is either the core clock or one of a set of single-cycle event strobes, such as instruction cache misses, data cache misses or mispredicted branches. A counter adds at most one per clock. One global control word gates the whole bank:
- a facility-off bit stops all counting;
- a freeze bit holds every counter;
- an arm bit lets the first qualifying overflow set the freeze bit by itself;
- an interrupt-enable bit allows overflows to reach the interrupt line.

Software reaches the registers through a single-cycle register port that carries a privilege flag. A privileged access can read and write each register at its normal address. Every register also appears at a mirror address, marked by the top address bit. Any access may read a mirror address, but no access may write it. Illegal accesses are refused with an error flag.

A counter is in the overflow state while its top bit is 1. Once all ones, it stays there until software writes a value with the top bit clear. The interrupt request rises only when four conditions hold together: some counter is in the overflow state, that counter's local overflow enable is set, the global interrupt enable is set, and the core's external interrupt-enable input is high.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the global control word reads 0x2 (frozen, all other bits 0), every counter and every local control word reads 0, and irq_o is low.
- R2: Local control bits [2:0] select the source: code 0 counts every clock, and code k (1..7) counts cycles in which evt_i[k-1] is high. A running counter adds exactly one per such cycle.
- R3: While global control bit 0 (facility off) is 1, no counter changes.
- R4: While global control bit 1 (freeze) is 1, no counter changes. Clearing it resumes counting.
- R5: When global control bit 2 (arm) is 1 and some counter has its top bit set with its local overflow enable (local bit 8) set, freeze bit 1 is set on the next clock, and counters stop from the clock after that.
- R6: A counter that reaches all ones stays there (overflow state, top bit 1) until software writes it.
- R7: irq_o is high only when some counter has its top bit set and its local bit 8 set, global bit 3 is set, and ee_i is high.
- R8: Addresses use index addr_i[3:0]: 0 is the global control word, 1..4 are counters 0..3, and 5..8 are local control words 0..3. Setting addr_i[4] gives the read-only mirror, which returns the same data to any access without error.
- R9: A write by an unprivileged access, or a write to any mirror address, changes nothing and raises err_o.
- R10: An unprivileged read of a normal address, or any access to index 9..15, returns zero data with err_o high.
- R11: A software write to a counter wins over a counted event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 7 | Single-cycle event strobes |
| ee_i | input | 1 | External interrupt enable from the core |
| req_i | input | 1 | Register access this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| priv_i | input | 1 | Access is privileged |
| addr_i | input | 5 | Bit 4 selects the mirror; bits 3:0 are the register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during the request cycle |
| err_o | output | 1 | Access refused, valid during the request cycle |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the unit with its defaults: four 32-bit counters and seven strobes. With these defaults the top bit is reached only through writes. Because counters are writable, the bench loads values a few counts below the sign bit or below all ones. This puts overflow, saturation and freeze-on-overflow within a handful of strobes. Holding the bank frozen while loading makes every counted pulse an exact expected delta.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  // Global control bit positions
  localparam int GC_OFF_BIT = 0;
  localparam int GC_FRZ_BIT = 1;
  localparam int GC_ARM_BIT = 2;
  localparam int GC_IE_BIT  = 3;
  localparam int GC_W       = 4;

  // Local control: overflow signalling enable bit (select sits at the bottom)
  localparam int LC_OE_BIT  = 8;

  typedef struct packed {
    logic ovf_ie;
    logic arm;
    logic frz;
    logic off;
  } gctl_t;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_GCTL,
    ACC_CTR,
    ACC_LCTL
  } acc_kind_e;

endpackage

// File: rtl/pmu_access_dec.sv
module pmu_access_dec
  import pmu_pkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int IDX_W    = 4,
  parameter int SLOT_W   = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [IDX_W:0]    addr_i,
  output acc_kind_e         kind_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wr_o,
  output logic              rd_ok_o,
  output logic              err_o
);

  logic             mirror;
  logic [IDX_W-1:0] idx;
  logic             legal_rd;
  logic             legal_wr;

  assign mirror = addr_i[IDX_W];
  assign idx    = addr_i[IDX_W-1:0];

  always_comb begin
    kind_o = ACC_NONE;
    slot_o = '0;
    if (idx == '0) begin
      kind_o = ACC_GCTL;
    end
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (idx == IDX_W'(1 + i)) begin
        kind_o = ACC_CTR;
        slot_o = SLOT_W'(i);
      end
      if (idx == IDX_W'(1 + NUM_CTRS + i)) begin
        kind_o = ACC_LCTL;
        slot_o = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    legal_rd = (kind_o != ACC_NONE) && (priv_i || mirror);
    legal_wr = (kind_o != ACC_NONE) && priv_i && !mirror;
    wr_o     = req_i && we_i && legal_wr;
    rd_ok_o  = req_i && !we_i && legal_rd;
    err_o    = req_i && (we_i ? !legal_wr : !legal_rd);
  end

endmodule

// File: rtl/pmu_global_ctl.sv
module pmu_global_ctl
  import pmu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [GC_W-1:0] wdata_i,
  input  logic            trig_i,
  output gctl_t           gctl_o,
  output logic            run_o
);

  gctl_t gctl_q;
  gctl_t gctl_d;
  logic  gctl_en;

  always_comb begin
    gctl_d  = gctl_q;
    gctl_en = 1'b0;
    if (we_i) begin
      gctl_d.off    = wdata_i[GC_OFF_BIT];
      gctl_d.frz    = wdata_i[GC_FRZ_BIT];
      gctl_d.arm    = wdata_i[GC_ARM_BIT];
      gctl_d.ovf_ie = wdata_i[GC_IE_BIT];
      gctl_en       = 1'b1;
    end else if (gctl_q.arm && trig_i && !gctl_q.frz) begin
      gctl_d.frz = 1'b1;
      gctl_en    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q <= '{ovf_ie: 1'b0, arm: 1'b0, frz: 1'b1, off: 1'b0};
    end else if (gctl_en) begin
      gctl_q <= gctl_d;
    end
  end

  assign gctl_o = gctl_q;
  assign run_o  = !gctl_q.off && !gctl_q.frz;

  // R5: an armed unit freezes itself one clock after a qualifying overflow
  a_r5_auto_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gctl_q.arm && trig_i && !we_i) |=> gctl_q.frz);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 7,
  parameter int SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ctr_we_i,
  input  logic               lc_we_i,
  input  logic [CTR_W-1:0]   wdata_i,
  output logic [CTR_W-1:0]   cnt_o,
  output logic [CTR_W-1:0]   lctl_o,
  output logic               ovf_sig_o
);

  localparam int EXT_W = 2 ** SEL_W;

  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             oe_q, oe_d;
  logic [EXT_W-1:0] src_vec;
  logic             hit;
  logic             sat;
  logic             inc;

  // Source vector: entry 0 is the clock itself, entries 1..NUM_EVT the strobes
  always_comb begin
    src_vec              = '0;
    src_vec[NUM_EVT:0]   = {evt_i, 1'b1};
    hit                  = src_vec[sel_q];
    sat                  = &cnt_q;
    inc                  = run_i && hit && !sat;
  end

  always_comb begin
    cnt_en = ctr_we_i || inc;
    if (ctr_we_i) begin
      cnt_d = wdata_i;
    end else begin
      cnt_d = cnt_q + CTR_W'(1);
    end
  end

  always_comb begin
    sel_d = wdata_i[SEL_W-1:0];
    oe_d  = wdata_i[LC_OE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      oe_q  <= 1'b0;
    end else if (lc_we_i) begin
      sel_q <= sel_d;
      oe_q  <= oe_d;
    end
  end

  always_comb begin
    lctl_o            = '0;
    lctl_o[SEL_W-1:0] = sel_q;
    lctl_o[LC_OE_BIT] = oe_q;
  end

  assign cnt_o     = cnt_q;
  assign ovf_sig_o = cnt_q[CTR_W-1] && oe_q;

  // R6: overflow state is left only through a software write
  a_r6_sticky_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[CTR_W-1] && !ctr_we_i) |=> cnt_q[CTR_W-1]);

  // R2: without a write the count moves by zero or one per clock
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctr_we_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CTR_W'($past(cnt_q) + 1))));

  // R3/R4: a halted bank holds its value
  a_r4_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ctr_we_i) |=> $stable(cnt_q));

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int CTR_W    = 32,
  parameter int NUM_EVT  = 7
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_EVT-1:0]                  evt_i,
  input  logic                                ee_i,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic                                priv_i,
  input  logic [$clog2(2*NUM_CTRS+1):0]       addr_i,
  input  logic [CTR_W-1:0]                    wdata_i,
  output logic [CTR_W-1:0]                    rdata_o,
  output logic                                err_o,
  output logic                                irq_o
);

  localparam int IDX_W  = $clog2(2 * NUM_CTRS + 1);
  localparam int SLOT_W = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;
  localparam int SEL_W  = $clog2(NUM_EVT + 1);

  // Reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  acc_kind_e         kind;
  logic [SLOT_W-1:0] slot;
  logic              wr;
  logic              rd_ok;
  gctl_t             gctl;
  logic              run;
  logic              trig;
  logic [NUM_CTRS-1:0] ovf_sig;
  logic [NUM_CTRS-1:0] ctr_we;
  logic [NUM_CTRS-1:0] lc_we;
  logic [CTR_W-1:0]  cnt  [NUM_CTRS];
  logic [CTR_W-1:0]  lctl [NUM_CTRS];

  pmu_access_dec #(
    .NUM_CTRS (NUM_CTRS),
    .IDX_W    (IDX_W),
    .SLOT_W   (SLOT_W)
  ) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .priv_i  (priv_i),
    .addr_i  (addr_i),
    .kind_o  (kind),
    .slot_o  (slot),
    .wr_o    (wr),
    .rd_ok_o (rd_ok),
    .err_o   (err_o)
  );

  pmu_global_ctl u_gctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (wr && (kind == ACC_GCTL)),
    .wdata_i (wdata_i[GC_W-1:0]),
    .trig_i  (trig),
    .gctl_o  (gctl),
    .run_o   (run)
  );

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    assign ctr_we[g] = wr && (kind == ACC_CTR)  && (slot == SLOT_W'(g));
    assign lc_we[g]  = wr && (kind == ACC_LCTL) && (slot == SLOT_W'(g));

    pmu_counter #(
      .CTR_W   (CTR_W),
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W)
    ) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .run_i     (run),
      .evt_i     (evt_i),
      .ctr_we_i  (ctr_we[g]),
      .lc_we_i   (lc_we[g]),
      .wdata_i   (wdata_i),
      .cnt_o     (cnt[g]),
      .lctl_o    (lctl[g]),
      .ovf_sig_o (ovf_sig[g])
    );
  end

  assign trig  = |ovf_sig;
  assign irq_o = trig && gctl.ovf_ie && ee_i;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      unique case (kind)
        ACC_GCTL: rdata_o[GC_W-1:0] = gctl;
        ACC_CTR:  rdata_o = cnt[slot];
        ACC_LCTL: rdata_o = lctl[slot];
        default:  rdata_o = '0;
      endcase
    end
  end

  // R9: unprivileged writes never reach any register
  a_r9_user_no_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_i && we_i && !priv_i) |-> (ctr_we == '0 && lc_we == '0 && !wr));

  // R10: an unprivileged read of a normal address yields zero with an error
  a_r10_user_read_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_i && !we_i && !priv_i && !addr_i[IDX_W]) |-> (rdata_o == '0 && err_o));

endmodule

// File: tb/perf_mon_unit_bench.sv
`timescale 1ns/1ps
module perf_mon_unit_bench;

  localparam int AW  = 5;
  localparam logic [AW-1:0] A_GC  = 5'd0;
  localparam logic [AW-1:0] A_MIR = 5'd16;

  logic        clk;
  logic        rst_n;
  logic [6:0]  evt;
  logic        ee;
  logic        req, we, priv;
  logic [AW-1:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  perf_mon_unit u_perf_mon_unit (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .evt_i   (evt),
    .ee_i    (ee),
    .req_i   (req),
    .we_i    (we),
    .priv_i  (priv),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .err_o   (err),
    .irq_o   (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] a_ctr(int i);
    return AW'(1 + i);
  endfunction

  function automatic logic [AW-1:0] a_lc(int i);
    return AW'(5 + i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic p, logic [AW-1:0] a, logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b1; priv = p; addr = a; wdata = d;
    #1 e = err;
    @(negedge clk);
    req = 1'b0; we = 1'b0; priv = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic do_read(logic p, logic [AW-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b0; priv = p; addr = a;
    #1 d = rdata; e = err;
    @(negedge clk);
    req = 1'b0; priv = 1'b0; addr = '0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    logic e;
    do_write(1'b1, a, d, e);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    logic e;
    do_read(1'b1, a, d, e);
  endtask

  task automatic pulse(logic [6:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_GC, d);  chk("R1 gctl", d, 32'h2);
    for (int i = 0; i < 4; i++) begin
      rd(a_ctr(i), d); chk("R1 counter", d, 32'h0);
      rd(a_lc(i), d);  chk("R1 local ctl", d, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clock_count;
    logic [31:0] d;
    // counter 3 keeps select 0 (clock); unfreeze, wait 3, freeze => 5 edges
    wr(a_ctr(3), 32'h0);
    wr(A_GC, 32'h0);
    repeat (3) @(negedge clk);
    wr(A_GC, 32'h2);
    rd(a_ctr(3), d); chk("R2 clock select", d, 32'd5);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr(a_lc(0), 32'h1);
    wr(a_lc(1), 32'h2);
    wr(a_lc(2), 32'h7);
    for (int i = 0; i < 3; i++) wr(a_ctr(i), 32'h0);
    wr(A_GC, 32'h0);
    pulse(7'h01);
    pulse(7'h43);
    pulse(7'h41);
    pulse(7'h00);
    wr(A_GC, 32'h2);
    rd(a_ctr(0), d); chk("R2 evt0 count", d, 32'd3);
    rd(a_ctr(1), d); chk("R2 evt1 count", d, 32'd1);
    rd(a_ctr(2), d); chk("R2 evt6 count", d, 32'd2);
    rd(a_lc(2), d);  chk("R8 local ctl read", d, 32'h7);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    // R4: frozen bank ignores strobes
    pulse(7'h01);
    pulse(7'h01);
    rd(a_ctr(0), d); chk("R4 frozen hold", d, 32'd3);
    // R3: facility off, freeze clear
    wr(A_GC, 32'h1);
    pulse(7'h01);
    pulse(7'h03);
    wr(A_GC, 32'h2);
    rd(a_ctr(0), d); chk("R3 off hold", d, 32'd3);
    rd(a_ctr(1), d); chk("R3 off hold c1", d, 32'd1);
  endtask

  task automatic t_write_wins;
    logic [31:0] d;
    wr(A_GC, 32'h0);
    @(negedge clk);
    evt = 7'h01; req = 1'b1; we = 1'b1; priv = 1'b1; addr = a_ctr(0); wdata = 32'd5;
    @(negedge clk);
    evt = '0; req = 1'b0; we = 1'b0; priv = 1'b0; addr = '0; wdata = '0;
    wr(A_GC, 32'h2);
    rd(a_ctr(0), d); chk("R11 write over event", d, 32'd5);
  endtask

  task automatic t_saturate_irq;
    logic [31:0] d;
    wr(a_ctr(0), 32'hFFFF_FFFE);
    wr(A_GC, 32'h0);
    pulse(7'h01);
    pulse(7'h01);
    pulse(7'h01);
    wr(A_GC, 32'h2);
    rd(a_ctr(0), d); chk("R6 saturate", d, 32'hFFFF_FFFF);
    wr(a_lc(0), 32'h101);
    wr(A_GC, 32'hA);
    ee = 1'b1;
    @(negedge clk); #1;
    chk("R7 all enables", {31'b0, irq}, 32'h1);
    ee = 1'b0;
    #1 chk("R7 ee low", {31'b0, irq}, 32'h0);
    ee = 1'b1;
    wr(a_lc(0), 32'h001);
    #1 chk("R7 local enable off", {31'b0, irq}, 32'h0);
    wr(a_lc(0), 32'h101);
    wr(A_GC, 32'h2);
    #1 chk("R7 global enable off", {31'b0, irq}, 32'h0);
    wr(A_GC, 32'hA);
    wr(a_ctr(0), 32'h7FFF_FFFF);
    #1 chk("R7 no overflow state", {31'b0, irq}, 32'h0);
    wr(a_ctr(0), 32'h8000_0000);
    #1 chk("R7 overflow state by write", {31'b0, irq}, 32'h1);
    ee = 1'b0;
    wr(a_ctr(0), 32'h0);
    wr(a_lc(0), 32'h1);
    wr(A_GC, 32'h2);
  endtask

  task automatic t_auto_freeze;
    logic [31:0] d;
    wr(a_ctr(1), 32'h7FFF_FFFE);
    wr(a_lc(1), 32'h102);
    wr(A_GC, 32'h4);
    pulse(7'h02);
    pulse(7'h02);
    pulse(7'h02);
    pulse(7'h02);
    rd(A_GC, d);     chk("R5 freeze bit set", d, 32'h6);
    rd(a_ctr(1), d); chk("R5 stopped after overflow", d, 32'h8000_0000);
    chk("R5 no irq without enable", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_access;
    logic [31:0] d;
    logic e;
    do_read(1'b1, A_MIR | a_ctr(1), d, e);
    chk("R8 priv mirror data", d, 32'h8000_0000); chk("R8 priv mirror err", {31'b0, e}, 32'h0);
    do_read(1'b0, A_MIR | a_ctr(1), d, e);
    chk("R8 user mirror data", d, 32'h8000_0000); chk("R8 user mirror err", {31'b0, e}, 32'h0);
    do_read(1'b0, A_MIR | A_GC, d, e);
    chk("R8 user mirror gctl", d, 32'h6);
    do_write(1'b0, a_ctr(1), 32'h0, e);
    chk("R9 user write err", {31'b0, e}, 32'h1);
    rd(a_ctr(1), d); chk("R9 user write ignored", d, 32'h8000_0000);
    do_write(1'b1, A_MIR | a_ctr(1), 32'h0, e);
    chk("R9 mirror write err", {31'b0, e}, 32'h1);
    rd(a_ctr(1), d); chk("R9 mirror write ignored", d, 32'h8000_0000);
    do_write(1'b0, A_MIR | A_GC, 32'h0, e);
    chk("R9 user mirror write err", {31'b0, e}, 32'h1);
    rd(A_GC, d); chk("R9 gctl kept", d, 32'h6);
    do_read(1'b0, a_ctr(1), d, e);
    chk("R10 user read data", d, 32'h0); chk("R10 user read err", {31'b0, e}, 32'h1);
    do_read(1'b1, AW'(12), d, e);
    chk("R10 bad index data", d, 32'h0); chk("R10 bad index err", {31'b0, e}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; ee = 1'b0;
    req = 1'b0; we = 1'b0; priv = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_clock_count();
    t_events();
    t_halt();
    t_write_wins();
    t_saturate_irq();
    t_auto_freeze();
    t_access();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule